// File: doc/BRIEF.md
# Teletype Output Controller

This block is the character-output device of a 12-bit accumulator machine. The CPU offers each I/O-transfer instruction it executes, together with the low byte of its accumulator and its current program counter. When the instruction is addressed to this device, the block updates an 11-bit control register. It answers a skip-on-done test, or flags an unsupported function code.

The control register is laid out as follows:

- bits 7:0 hold the stored character, with bit 7 inverted;
- bit 8 marks a pending character;
- bit 9 is the done flag;
- bit 10 is an auxiliary bit.

A pending character is offered to a downstream sink over a valid/ready handshake. Once the sink accepts it, the block clears the character and pending bits and counts a programmable number of clock cycles. At the end of that count it raises the done flag.

The CPU uses the `pc_next` output in place of its own incremented PC whenever `skip` is high. A skip advances only the low 12 bits, which wrap around; the upper field bits stay unchanged. Keyboard input and combined input/output tests are outside this block.

Top module: `tto_iot_ctrl`

## Requirements
- R1: An instruction is accepted only when `instr_valid` is high, `instr[11:9]` is 6 and `instr[8:3]` is octal 04. Any other instruction changes no state and raises neither `skip` nor `illegal`.
- R2: Function 0 (`instr[2:0]`=0) loads the control register with 0x600 at the next clock edge, which sets the done flag (bit 9) and bit 10.
- R3: Function 1 raises `skip` in the same cycle when the done flag is set. While `skip` is high, `pc_next` equals `pc_in` with bits 11:0 incremented modulo 4096 and the bits above 11 unchanged. Otherwise `pc_next` equals `pc_in`.
- R4: Function 2 clears the whole control register at the next edge.
- R5: Function 4 writes (acc_byte XOR 0x80) into bits 7:0 and sets bit 8. Bits 10:9 keep their value.
- R6: Function 6 writes the character and bit 8 as in R5 and clears bits 10:9.
- R7: `tx_valid` equals bit 8 and `tx_data` equals bits 7:0 XOR 0x80. Both hold steady until `tx_ready` is high. The edge that completes the handshake clears bits 8:0.
- R8: If no function 0/2/4/6 write occurs meanwhile, the done flag becomes set at the DELAY-th rising edge after the handshake edge.
- R9: A function 0, 2, 4 or 6 write cancels a running delay, so no done flag follows from it. A write in the same cycle as a handshake takes precedence over the clearing of bits 8:0.
- R10: Function codes 3, 5 and 7 raise `illegal` in the same cycle and leave bits 10 and 8:0 unchanged.
- R11: After reset the control register is zero and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered this cycle |
| instr | input | 12 | Instruction word |
| acc_byte | input | 8 | Low byte of the accumulator |
| pc_in | input | PC_W | Incremented program counter from the CPU |
| pc_next | output | PC_W | Program counter after an optional skip |
| skip | output | 1 | Skip request for the next instruction |
| illegal | output | 1 | Unsupported function code for this device |
| ctrl | output | 11 | Control register contents |
| tx_valid | output | 1 | Character offered to the sink |
| tx_data | output | 8 | Character to the sink |
| tx_ready | input | 1 | Sink accepts the character |

## Verification
`skip`, `illegal` and `pc_next` are combinational and belong to the cycle in which the instruction is offered. Control-register updates, including the new `tx_valid`, appear after the next rising edge. The done flag appears DELAY edges after the handshake edge. The bench drives inputs at the falling edge and compares every output 1 ns later against a behavioural model evaluated with the same inputs. It advances that model only at the rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/tto_iot_ctrl.sv
module tto_iot_ctrl #(
  parameter int DELAY = 100,
  parameter int PC_W  = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [11:0]     instr,
  input  logic [7:0]      acc_byte,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] pc_next,
  output logic            skip,
  output logic            illegal,
  output logic [10:0]     ctrl,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  input  logic            tx_ready
);
  localparam int          CW     = $clog2(DELAY + 1);
  localparam logic [2:0]  OP_IOT = 3'd6;
  localparam logic [5:0]  DEV_ID = 6'o04;

  logic          sel, wr, fire;
  logic [2:0]    fn;
  logic [7:0]    chr;
  logic [10:0]   ctrl_q;
  logic [CW-1:0] cnt;

  assign sel  = instr_valid && instr[11:9] == OP_IOT && instr[8:3] == DEV_ID;
  assign fn   = instr[2:0];
  assign wr   = sel && !fn[0];
  assign chr  = acc_byte ^ 8'h80;

  assign illegal  = sel && fn[0] && fn != 3'd1;
  assign skip     = sel && fn == 3'd1 && ctrl_q[9];
  assign pc_next  = {pc_in[PC_W-1:12], pc_in[11:0] + {11'd0, skip}};

  assign tx_valid = ctrl_q[8];
  assign tx_data  = ctrl_q[7:0] ^ 8'h80;
  assign fire     = tx_valid && tx_ready;
  assign ctrl     = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt    <= '0;
    end else if (wr) begin
      cnt <= '0;
      case (fn)
        3'd0:    ctrl_q <= 11'h600;
        3'd2:    ctrl_q <= '0;
        3'd4:    ctrl_q <= {ctrl_q[10:9], 1'b1, chr};
        default: ctrl_q <= {2'b00, 1'b1, chr};
      endcase
    end else if (fire) begin
      ctrl_q[8:0] <= '0;
      cnt         <= CW'(DELAY);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) ctrl_q[9] <= 1'b1;
    end
  end
endmodule

// File: rtl/tto_iot_chk.sv
module tto_iot_chk #(
  parameter int DELAY = 100,
  parameter int PC_W  = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [11:0]     instr,
  input logic [7:0]      acc_byte,
  input logic [PC_W-1:0] pc_in,
  input logic [PC_W-1:0] pc_next,
  input logic            skip,
  input logic            illegal,
  input logic [10:0]     ctrl,
  input logic            tx_valid,
  input logic [7:0]      tx_data,
  input logic            tx_ready
);
  logic        s, w, hs, armed;
  logic [2:0]  f;
  logic [31:0] since;

  assign s  = instr_valid && instr[11:9] == 3'd6 && instr[8:3] == 6'o04;
  assign f  = instr[2:0];
  assign w  = s && (f == 3'd0 || f == 3'd2 || f == 3'd4 || f == 3'd6);
  assign hs = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      since <= '0;
    end else if (w) begin
      armed <= 1'b0;
    end else if (hs) begin
      armed <= 1'b1;
      since <= '0;
    end else if (armed && since != 32'hFFFF_FFFF) begin
      since <= since + 32'd1;
    end
  end

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !s |-> !skip && !illegal); // R1
  AST_F0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    s && f == 3'd0 |=> ctrl == 11'h600); // R2
  AST_SKIP_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    s && f == 3'd1 |-> skip == ctrl[9]); // R3
  AST_SKIP_PC: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> pc_next[11:0] == pc_in[11:0] + 12'd1 && pc_next[PC_W-1:12] == pc_in[PC_W-1:12]); // R3
  AST_F2_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    s && f == 3'd2 |=> ctrl == 11'h000); // R4
  AST_F4_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    s && f == 3'd4 |=> ctrl[10:9] == $past(ctrl[10:9]) && ctrl[8] && ctrl[7:0] == ($past(acc_byte) ^ 8'h80)); // R5
  AST_F6_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    s && f == 3'd6 |=> ctrl[10:9] == 2'b00 && ctrl[8] && ctrl[7:0] == ($past(acc_byte) ^ 8'h80)); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !w |=> tx_valid && $stable(tx_data)); // R7
  AST_EMIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !w |=> ctrl[8:0] == 9'd0); // R7
  AST_DONE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl[9]) && !$past(w) |-> armed && since == DELAY); // R8
  AST_DONE_AFTER_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl[9]) && !armed |-> $past(w)); // R9
  AST_ILLEGAL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal && !tx_valid |=> ctrl[10] == $past(ctrl[10]) && ctrl[8:0] == $past(ctrl[8:0])); // R10
  AST_ILLEGAL_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !skip); // R10
endmodule

bind tto_iot_ctrl tto_iot_chk #(.DELAY(DELAY), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
  .acc_byte(acc_byte), .pc_in(pc_in), .pc_next(pc_next), .skip(skip),
  .illegal(illegal), .ctrl(ctrl), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_ready(tx_ready)
);

// File: tb/sim_tto_iot_ctrl.sv
`timescale 1ns/1ps
module sim_tto_iot_ctrl;
  localparam int D  = 6;
  localparam int PW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_valid = 1'b0;
  logic [11:0]   instr = '0;
  logic [7:0]    acc_byte = '0;
  logic [PW-1:0] pc_in = '0;
  logic [PW-1:0] pc_next;
  logic          skip, illegal, tx_valid, tx_ready = 1'b0;
  logic [10:0]   ctrl;
  logic [7:0]    tx_data;

  int n_cmp = 0, n_bad = 0, cyc_n = 0;
  int m_ctrl = 0, m_cnt = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  tto_iot_ctrl #(.DELAY(D), .PC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .acc_byte(acc_byte), .pc_in(pc_in), .pc_next(pc_next), .skip(skip),
    .illegal(illegal), .ctrl(ctrl), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc_n, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [11:0] iot(input int fn);
    return {3'd6, 6'o04, 3'(fn)};
  endfunction

  task automatic step(input logic v, input logic [11:0] w, input logic [7:0] a,
                      input logic [PW-1:0] pc, input logic rdy);
    bit sel, wr, e_skip, e_ill;
    int f, e_pc;
    @(negedge clk);
    instr_valid = v; instr = w; acc_byte = a; pc_in = pc; tx_ready = rdy;
    #1;
    sel    = v && w[11:9] == 3'd6 && w[8:3] == 6'o04;
    f      = int'(w[2:0]);
    wr     = sel && (f % 2 == 0);
    e_skip = sel && f == 1 && (m_ctrl & 'h200) != 0;
    e_ill  = sel && (f == 3 || f == 5 || f == 7);
    e_pc   = e_skip ? ((int'(pc) & ~'o7777) | ((int'(pc) + 1) & 'o7777)) : int'(pc);
    chk("R1 R3 skip", int'(skip), int'(e_skip));
    chk("R3 pc_next", int'(pc_next), e_pc);
    chk("R1 R10 illegal", int'(illegal), int'(e_ill));
    chk("R2 R4 R5 R6 R8 R9 R10 ctrl", int'(ctrl), m_ctrl);
    chk("R7 tx_valid", int'(tx_valid), (m_ctrl >> 8) & 1);
    chk("R7 tx_data", int'(tx_data), (m_ctrl & 'hFF) ^ 'h80);
    @(posedge clk);
    cyc_n++;
    if (wr) begin
      m_cnt = 0;
      if (f == 0) m_ctrl = 'h600;
      else if (f == 2) m_ctrl = 0;
      else if (f == 4) m_ctrl = (m_ctrl & 'h600) | 'h100 | (int'(a) ^ 'h80);
      else m_ctrl = 'h100 | (int'(a) ^ 'h80);
    end else if ((m_ctrl & 'h100) != 0 && rdy) begin
      m_ctrl = m_ctrl & ~'h1FF;
      m_cnt = D;
    end else if (m_cnt > 0) begin
      if (m_cnt == 1) m_ctrl = m_ctrl | 'h200;
      m_cnt--;
    end
  endtask

  task automatic idle(input int n, input logic rdy);
    for (int i = 0; i < n; i++) step(1'b0, 12'o0000, 8'h00, 15'o00200, rdy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset ctrl", int'(ctrl), 0);
    chk("R11 reset tx_valid", int'(tx_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, 1'b1);
    // R3: no skip while done clear
    step(1'b1, iot(1), 8'h00, 15'o17777, 1'b1);
    // R2 then R3 with low-field wrap
    step(1'b1, iot(0), 8'h00, 15'o00300, 1'b1);
    step(1'b1, iot(1), 8'h00, 15'o17777, 1'b1);
    step(1'b1, iot(1), 8'h00, 15'o20155, 1'b1);
    // R1: other device, other opcode
    step(1'b1, 12'o6052, 8'h11, 15'o00400, 1'b1);
    step(1'b1, 12'o5042, 8'h11, 15'o00400, 1'b1);
    step(1'b0, iot(2), 8'h11, 15'o00400, 1'b1);
    // R4
    step(1'b1, iot(2), 8'h00, 15'o00400, 1'b1);
    step(1'b1, iot(1), 8'h00, 15'o00401, 1'b1);
    // R6, R7 hold while not ready, R8 delay
    step(1'b1, iot(6), 8'h41, 15'o00500, 1'b0);
    idle(4, 1'b0);
    idle(D + 3, 1'b1);
    step(1'b1, iot(1), 8'h00, 15'o07777, 1'b1);
    // R5: done kept across a function-4 load
    step(1'b1, iot(4), 8'hC3, 15'o00600, 1'b0);
    idle(2, 1'b0);
    step(1'b1, iot(1), 8'h00, 15'o00601, 1'b0);
    idle(D + 2, 1'b1);
    // R9: restart during the delay
    step(1'b1, iot(6), 8'h5A, 15'o00700, 1'b1);
    idle(3, 1'b1);
    step(1'b1, iot(4), 8'h10, 15'o00701, 1'b0);
    idle(2, 1'b0);
    idle(D + 2, 1'b1);
    // R9: write beats a handshake in the same cycle
    step(1'b1, iot(6), 8'h7E, 15'o01000, 1'b0);
    step(1'b1, iot(4), 8'h23, 15'o01001, 1'b1);
    step(1'b1, iot(2), 8'h00, 15'o01002, 1'b0);
    // R6 clears bit 10 after R2
    step(1'b1, iot(0), 8'h00, 15'o01100, 1'b0);
    step(1'b1, iot(6), 8'hFF, 15'o01101, 1'b0);
    // R10 illegal codes with a pending byte
    step(1'b1, iot(3), 8'h99, 15'o01200, 1'b0);
    step(1'b1, iot(5), 8'h99, 15'o01201, 1'b0);
    step(1'b1, iot(7), 8'h99, 15'o01202, 1'b0);
    idle(D + 3, 1'b1);
    step(1'b1, iot(5), 8'h00, 15'o01300, 1'b1);
    step(1'b1, iot(1), 8'h00, 15'o01301, 1'b1);
    idle(2, 1'b1);
    finish_run();
  end
endmodule